// File: doc/BRIEF.md
# Fetch Redirect Controller with Resume Buffer

This block steers a four-wide instruction fetch front end. It presents a new group address every cycle and, when nothing else happens, moves it forward by one group (16 bytes). Branches are found one stage later, in decode. When decode flags a branch predicted taken, fetch has already read the sequential group that follows it. That group is lost for the predicted path and costs one bubble cycle. The block does not discard it. It saves the group, the group's address and the branch tag in a small age-ordered resume buffer, and then sends fetch to the predicted target.

Branches resolve several cycles later. A branch that resolves taken as predicted releases its buffer entry. A branch that resolves not taken is a misprediction. In that case the entry and every younger entry are dropped. In the next cycle decode is fed the saved group from the buffer, and fetch restarts one group past the saved address, so the saved instructions are not fetched again. If the buffer is full when decode flags another predicted-taken branch, the block holds fetch and asks decode to hold the branch.

Top module: `fetch_redirect`

## Requirements
- R1: While reset is active and in the first cycle after it, `fetch_pc_o` equals `RESET_PC`, `dec_src_o` is 0 and `dec_hold_o` is 0.
- R2: In a cycle with no stall, no predicted-taken branch and no misprediction, `fetch_pc_o` goes up by 16 (group bytes) at the next edge.
- R3: While `stall_i` is high and no misprediction occurs, `fetch_pc_o` holds and a predicted-taken branch in decode is not accepted.
- R4: An accepted predicted-taken branch (buffer not full, no stall, no misprediction) loads `dec_target_i` into `fetch_pc_o` at the next edge. In the same cycle the group then at fetch is saved: its address `fetch_pc_o`, its data `fetch_data_i` (lane 0 in bits 31:0, lane i at address + 4*i) and `dec_tag_i`.
- R5: A resolve that matches a buffered tag and has `res_taken_i`=1 frees that entry and does not change the fetch path. The freed slot can then accept a new predicted-taken branch.
- R6: A resolve that matches a buffered tag and has `res_taken_i`=0 is a misprediction. At the next edge `dec_src_o` becomes 1, `resume_pc_o`/`resume_data_o` show the saved group, and `fetch_pc_o` becomes the saved address + 16. A predicted-taken branch in decode in the same cycle is ignored.
- R7: A misprediction frees its own entry and every younger entry. Older entries stay and can still be recovered.
- R8: With `DEPTH` entries held, a predicted-taken branch raises `dec_hold_o` in the same cycle, `fetch_pc_o` holds, and nothing is saved.
- R9: A resolve whose tag matches no held entry has no effect.
- R10: `dec_src_o` stays 1 while `stall_i` is high and returns to 0 after the first unstalled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Downstream stall, freezes fetch and decode |
| fetch_data_i | input | 128 | Group read at `fetch_pc_o` this cycle |
| dec_taken_i | input | 1 | Decode holds a predicted-taken branch |
| dec_target_i | input | 32 | Predicted target of that branch |
| dec_tag_i | input | 3 | Tag of that branch |
| res_valid_i | input | 1 | A branch outcome is resolved this cycle |
| res_tag_i | input | 3 | Tag of the resolved branch |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |
| fetch_pc_o | output | 32 | Fetch group address |
| dec_src_o | output | 1 | Decode source: 0 = cache, 1 = resume buffer |
| resume_pc_o | output | 32 | Address of the group replayed to decode |
| resume_data_o | output | 128 | Group replayed to decode |
| dec_hold_o | output | 1 | Decode must hold its branch because the buffer is full |

## Verification
The bench uses the defaults: four lanes, 32-bit addresses, a 3-bit tag and a buffer depth of 4. With depth 4 the buffer can be filled in a few cycles, so the full-buffer hold, a free followed by a shift, and a recovery from the middle of the buffer are all short directed sequences. The 3-bit tag leaves room for a resolve whose tag is not held. The cache model puts each lane's own address in its data, so a replayed group can be checked exactly against the address saved for it.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic {
    SRC_CACHE  = 1'b0,
    SRC_RESUME = 1'b1
  } dec_src_e;
endpackage

// File: rtl/fr_resume_buf.sv
module fr_resume_buf #(
  parameter int ADDR_W = 32,
  parameter int GRP_W  = 128,
  parameter int TAG_W  = 3,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_pc_i,
  input  logic [GRP_W-1:0]  push_data_i,
  input  logic [TAG_W-1:0]  push_tag_i,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic              res_taken_i,
  output logic              full_o,
  output logic              mis_o,
  output logic [ADDR_W-1:0] mis_pc_o,
  output logic [GRP_W-1:0]  mis_data_o,
  output logic [CNT_W-1:0]  cnt_o
);
  // index 0 is the oldest entry
  logic [ADDR_W-1:0] pc_q   [DEPTH];
  logic [GRP_W-1:0]  data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  logic [ADDR_W-1:0] pc_n   [DEPTH];
  logic [GRP_W-1:0]  data_n [DEPTH];
  logic [TAG_W-1:0]  tag_n  [DEPTH];
  logic [CNT_W-1:0]  cnt_n;

  logic             hit, ok_free;
  logic [IDX_W-1:0] idx;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CNT_W'(i) < cnt_q && tag_q[i] == res_tag_i) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign mis_o      = res_valid_i & hit & ~res_taken_i;
  assign ok_free    = res_valid_i & hit & res_taken_i;
  assign mis_pc_o   = pc_q[idx];
  assign mis_data_o = data_q[idx];
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
  assign cnt_o      = cnt_q;

  always_comb begin
    pc_n   = pc_q;
    data_n = data_q;
    tag_n  = tag_q;
    cnt_n  = cnt_q;
    if (mis_o) begin
      cnt_n = CNT_W'(idx);
    end else begin
      if (ok_free) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          if (IDX_W'(i) >= idx) begin
            pc_n[i]   = pc_q[i+1];
            data_n[i] = data_q[i+1];
            tag_n[i]  = tag_q[i+1];
          end
        end
        cnt_n = cnt_q - 1'b1;
      end
      if (push_i && cnt_n < CNT_W'(DEPTH)) begin
        pc_n[cnt_n[IDX_W-1:0]]   = push_pc_i;
        data_n[cnt_n[IDX_W-1:0]] = push_data_i;
        tag_n[cnt_n[IDX_W-1:0]]  = push_tag_i;
        cnt_n = cnt_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        pc_q[i]   <= '0;
        data_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      cnt_q  <= cnt_n;
      pc_q   <= pc_n;
      data_q <= data_n;
      tag_q  <= tag_n;
    end
  end
endmodule

// File: rtl/fr_pc_gen.sv
module fr_pc_gen #(
  parameter int              ADDR_W   = 32,
  parameter int              GROUP_B  = 16,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mis_i,
  input  logic [ADDR_W-1:0] mis_pc_i,
  input  logic              hold_i,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(GROUP_B);

  logic [ADDR_W-1:0] pc_q, pc_n;

  always_comb begin
    if (mis_i)       pc_n = mis_pc_i + STEP;
    else if (hold_i) pc_n = pc_q;
    else if (take_i) pc_n = target_i;
    else             pc_n = pc_q + STEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RESET_PC;
    else         pc_q <= pc_n;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect #(
  parameter int                ADDR_W   = 32,
  parameter int                INSN_W   = 32,
  parameter int                LANES    = 4,
  parameter int                DEPTH    = 4,
  parameter int                TAG_W    = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_1000,
  localparam int               GRP_W    = INSN_W * LANES,
  localparam int               GROUP_B  = GRP_W / 8,
  localparam int               CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [GRP_W-1:0]  fetch_data_i,
  input  logic              dec_taken_i,
  input  logic [ADDR_W-1:0] dec_target_i,
  input  logic [TAG_W-1:0]  dec_tag_i,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic              res_taken_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic              dec_src_o,
  output logic [ADDR_W-1:0] resume_pc_o,
  output logic [GRP_W-1:0]  resume_data_o,
  output logic              dec_hold_o
);
  import fr_pkg::*;

  logic              mis, full, take;
  logic [ADDR_W-1:0] mis_pc;
  logic [GRP_W-1:0]  mis_data;
  logic [CNT_W-1:0]  buf_cnt;

  dec_src_e          src_q;
  logic [ADDR_W-1:0] rec_pc_q;
  logic [GRP_W-1:0]  rec_data_q;

  // a misprediction flushes decode, so its branch is neither held nor taken
  assign dec_hold_o = dec_taken_i & full & ~mis;
  assign take       = dec_taken_i & ~full & ~stall_i & ~mis;

  fr_resume_buf #(
    .ADDR_W (ADDR_W),
    .GRP_W  (GRP_W),
    .TAG_W  (TAG_W),
    .DEPTH  (DEPTH)
  ) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (take),
    .push_pc_i   (fetch_pc_o),
    .push_data_i (fetch_data_i),
    .push_tag_i  (dec_tag_i),
    .res_valid_i (res_valid_i),
    .res_tag_i   (res_tag_i),
    .res_taken_i (res_taken_i),
    .full_o      (full),
    .mis_o       (mis),
    .mis_pc_o    (mis_pc),
    .mis_data_o  (mis_data),
    .cnt_o       (buf_cnt)
  );

  fr_pc_gen #(
    .ADDR_W   (ADDR_W),
    .GROUP_B  (GROUP_B),
    .RESET_PC (RESET_PC)
  ) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mis_i    (mis),
    .mis_pc_i (mis_pc),
    .hold_i   (stall_i | dec_hold_o),
    .take_i   (take),
    .target_i (dec_target_i),
    .pc_o     (fetch_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q      <= SRC_CACHE;
      rec_pc_q   <= '0;
      rec_data_q <= '0;
    end else if (mis) begin
      src_q      <= SRC_RESUME;
      rec_pc_q   <= mis_pc;
      rec_data_q <= mis_data;
    end else if (!stall_i) begin
      src_q      <= SRC_CACHE;
    end
  end

  assign dec_src_o     = (src_q == SRC_RESUME);
  assign resume_pc_o   = rec_pc_q;
  assign resume_data_o = rec_data_q;
endmodule

// File: rtl/fetch_redirect_chk.sv
module fetch_redirect_chk #(
  parameter int ADDR_W  = 32,
  parameter int GROUP_B = 16,
  parameter int DEPTH   = 4,
  parameter int CNT_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              dec_taken_i,
  input logic [ADDR_W-1:0] dec_target_i,
  input logic [ADDR_W-1:0] fetch_pc_o,
  input logic              dec_src_o,
  input logic [ADDR_W-1:0] resume_pc_o,
  input logic              dec_hold_o,
  input logic              mis_i,
  input logic [ADDR_W-1:0] mis_pc_i,
  input logic [CNT_W-1:0]  cnt_i
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(GROUP_B);

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i && !dec_taken_i && !mis_i |=> fetch_pc_o == $past(fetch_pc_o) + STEP);

  // R3
  stall_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i && !mis_i |=> $stable(fetch_pc_o));

  // R4
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_taken_i && !dec_hold_o && !stall_i && !mis_i |=> fetch_pc_o == $past(dec_target_i));

  // R6
  recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mis_i |=> dec_src_o && resume_pc_o == $past(mis_pc_i)
              && fetch_pc_o == $past(mis_pc_i) + STEP);

  // R8
  hold_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_hold_o |-> dec_taken_i && cnt_i == CNT_W'(DEPTH));

  // R8
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(DEPTH));

  // R10
  src_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_src_o && !stall_i && !mis_i |=> !dec_src_o);
endmodule

bind fetch_redirect fetch_redirect_chk #(
  .ADDR_W  (ADDR_W),
  .GROUP_B (GROUP_B),
  .DEPTH   (DEPTH),
  .CNT_W   (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_i),
  .dec_taken_i  (dec_taken_i),
  .dec_target_i (dec_target_i),
  .fetch_pc_o   (fetch_pc_o),
  .dec_src_o    (dec_src_o),
  .resume_pc_o  (resume_pc_o),
  .dec_hold_o   (dec_hold_o),
  .mis_i        (mis),
  .mis_pc_i     (mis_pc),
  .cnt_i        (buf_cnt)
);

// File: tb/tb_fetch_redirect.sv
module tb_fetch_redirect;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  typedef struct packed {
    logic        stall;
    logic        tk;
    logic [2:0]  tag;
    logic [31:0] tgt;
    logic        rv;
    logic [2:0]  rtag;
    logic        rtk;
    logic [31:0] exp_pc;
    logic        exp_src;
    logic [31:0] exp_rpc;
  } vec_t;

  localparam int NVEC = 8;
  // R2 R3 R4 R6 R10 R9 walk from reset address
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 32'h1010, 1'b0, 32'h0},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 32'h1020, 1'b0, 32'h0},
    '{1'b1, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 32'h1020, 1'b0, 32'h0},
    '{1'b0, 1'b1, 3'd1, 32'h2000, 1'b0, 3'd0, 1'b0, 32'h2000, 1'b0, 32'h0},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 32'h2010, 1'b0, 32'h0},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 3'd1, 1'b0, 32'h1030, 1'b1, 32'h1020},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b0, 3'd0, 1'b0, 32'h1040, 1'b0, 32'h0},
    '{1'b0, 1'b0, 3'd0, 32'h0,    1'b1, 3'd5, 1'b0, 32'h1050, 1'b0, 32'h0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stall = 1'b0, tk = 1'b0, rv = 1'b0, rtk = 1'b0;
  logic [2:0]   tag = '0, rtag = '0;
  logic [31:0]  tgt = '0;
  logic [127:0] fdata;
  logic [31:0]  pc;
  logic         src, hold;
  logic [31:0]  rpc;
  logic [127:0] rdata;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] grp(input logic [31:0] a);
    return {a + 32'd12, a + 32'd8, a + 32'd4, a};
  endfunction

  assign fdata = grp(pc);

  fetch_redirect dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .stall_i       (stall),
    .fetch_data_i  (fdata),
    .dec_taken_i   (tk),
    .dec_target_i  (tgt),
    .dec_tag_i     (tag),
    .res_valid_i   (rv),
    .res_tag_i     (rtag),
    .res_taken_i   (rtk),
    .fetch_pc_o    (pc),
    .dec_src_o     (src),
    .resume_pc_o   (rpc),
    .resume_data_o (rdata),
    .dec_hold_o    (hold)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clr();
    stall = 1'b0; tk = 1'b0; tag = '0; tgt = '0;
    rv = 1'b0; rtag = '0; rtk = 1'b0;
  endtask

  // predicted-taken branch, returns the saved group address
  task automatic take_br(input logic [2:0] t, input logic [31:0] target, output logic [31:0] saved);
    saved = pc;
    tk = 1'b1; tag = t; tgt = target;
    cyc();
    clr();
    chk("R4", pc, target);
    cyc();
  endtask

  task automatic resolve(input logic [2:0] t, input logic taken);
    rv = 1'b1; rtag = t; rtk = taken;
    cyc();
    clr();
  endtask

  initial begin
    logic [31:0] s1, s2, s3, s4, d, p;
    clr();
    #(CLK_PERIOD * 2 + 1);
    // R1 during reset
    chk("R1", pc, RST_PC);
    chk("R1", src, 1'b0);
    chk("R1", hold, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1", pc, RST_PC);

    for (int i = 0; i < NVEC; i++) begin
      stall = VECS[i].stall; tk = VECS[i].tk; tag = VECS[i].tag; tgt = VECS[i].tgt;
      rv = VECS[i].rv; rtag = VECS[i].rtag; rtk = VECS[i].rtk;
      cyc();
      clr();
      chk("R2/R3/R4/R6/R9/R10 pc", pc, VECS[i].exp_pc);
      chk("R6/R10 src", src, VECS[i].exp_src);
      if (VECS[i].exp_src) begin
        chk("R6 rpc", rpc, VECS[i].exp_rpc);
        chk("R6 rdata", rdata, grp(VECS[i].exp_rpc));
      end
    end

    // R7: three entries, recover from the middle
    take_br(3'd1, 32'h3000, s1);
    take_br(3'd2, 32'h4000, s2);
    take_br(3'd3, 32'h5000, s3);
    resolve(3'd2, 1'b0);
    chk("R7 src", src, 1'b1);
    chk("R7 rpc", rpc, s2);
    chk("R7 rdata", rdata, grp(s2));
    chk("R7 pc", pc, s2 + 32'd16);
    p = pc;
    resolve(3'd3, 1'b0); // younger entry was dropped
    chk("R7 younger gone src", src, 1'b0);
    chk("R7 younger gone pc", pc, p + 32'd16);
    resolve(3'd1, 1'b0); // older entry still held
    chk("R7 older kept src", src, 1'b1);
    chk("R7 older kept rpc", rpc, s1);
    chk("R7 older kept pc", pc, s1 + 32'd16);
    cyc();

    // R8: fill the buffer
    take_br(3'd1, 32'h6000, s1);
    take_br(3'd2, 32'h7000, s2);
    take_br(3'd3, 32'h8000, s3);
    take_br(3'd4, 32'h9000, s4);
    p = pc;
    tk = 1'b1; tag = 3'd5; tgt = 32'hA000;
    #1;
    chk("R8 hold", hold, 1'b1);
    cyc();
    chk("R8 pc held", pc, p);
    chk("R8 hold again", hold, 1'b1);
    clr();
    #1;
    chk("R8 hold drops", hold, 1'b0);

    // R5: correct resolve frees a slot, no path change
    resolve(3'd1, 1'b1);
    chk("R5 pc", pc, p + 32'd16);
    chk("R5 src", src, 1'b0);
    tk = 1'b1; tag = 3'd5; tgt = 32'hA000;
    #1;
    chk("R5 slot free", hold, 1'b0);
    cyc();
    clr();
    chk("R5 accept", pc, 32'hA000);
    cyc();

    // R6 priority over decode branch, R7 after shift
    rv = 1'b1; rtag = 3'd2; rtk = 1'b0;
    tk = 1'b1; tag = 3'd6; tgt = 32'hB000;
    #1;
    chk("R6 no hold on flush", hold, 1'b0);
    cyc();
    clr();
    chk("R6 priority pc", pc, s2 + 32'd16);
    chk("R6 priority rpc", rpc, s2);
    chk("R6 priority src", src, 1'b1);

    // R10: stall keeps resume select
    d = pc;
    stall = 1'b1;
    cyc();
    chk("R10 src held", src, 1'b1);
    chk("R3 pc held", pc, d);
    stall = 1'b0;
    cyc();
    chk("R10 src release", src, 1'b0);
    chk("R2 pc", pc, d + 32'd16);

    // R9: tag of dropped entry (3) now unmatched
    p = pc;
    resolve(3'd3, 1'b0);
    chk("R9 src", src, 1'b0);
    chk("R9 pc", pc, p + 32'd16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule